// File: doc/BRIEF.md
# Banked data memory with indirect pointers

This block is the data-memory side of a small 8-bit core: it turns a direct byte address plus read and write strobes into an access to either a small special-register area or a general-purpose byte store. Addresses from 00H up to the general-purpose base (40H by default) form a special area seen identically from every bank. Above the base, three banks of 192 bytes hold general data.

Two addresses in the special area have no storage of their own and act as indirect ports. An access through the first port lands on the location named by the first pointer register, always in bank 0. An access through the second port lands on the location named by the second pointer register, in the bank picked by a bank-select register. Direct addressing reaches only bank 0. The pointers, the bank select and the accumulator are real registers in the special area. Every other special address reads as zero and ignores writes. Reads are combinational from the address; writes take effect on the rising clock edge while the write strobe is high.

Top module: `banked_dmem`

## Requirements
- R1: After reset, the first pointer (01H), the second pointer (03H), the bank select (04H) and the accumulator (05H) all read 00H.
- R2: A direct access to an address from 40H to FFH reads or writes that location in bank 0. Read data follows the address in the same cycle, and a write is visible from the clock edge that captures it.
- R3: An access to address 00H is redirected to the location held in the first pointer (01H), in bank 0, for both read and write.
- R4: An access to address 02H is redirected to the location held in the second pointer (03H). For a general-purpose target, the bank is the bank-select value 0, 1 or 2, and the three banks hold independent data at the same address.
- R5: When the pointer used by an indirect port holds 00H or 02H, a read through that port returns 00H and a write through it changes neither pointer nor the accumulator.
- R6: With bank select 3, a general-purpose access through 02H reads 00H and a write leaves the same location in banks 0, 1 and 2 unchanged.
- R7: A special address that holds no register (for example 10H or 3FH) reads 00H, even after a write to it.
- R8: The accumulator at 05H stores a written byte. It can also be reached through an indirect port whose pointer holds 05H.
- R9: The bank select register keeps only its two low bits and reads back zero-extended, so writing FEH reads back 02H.
- R10: While the read strobe is low, read data is 00H whatever the address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 8 | Direct byte address |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe, sampled at the clock edge |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational |

## Verification
The assertions take for granted that the address and strobes are settled at each rising edge and that read and write strobes are never both high. The stimulus drives every input on the falling edge and raises only one strobe per cycle. The general-purpose store has no reset, so the properties never reason about its contents, and the stimulus writes every location before it reads it back. The bank select is always loaded before it steers an access through the second port.

// File: rtl/banked_dmem_pkg.sv
package banked_dmem_pkg;
    localparam int AW = 8;
    localparam int DW = 8;
    localparam int BW = 2;

    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_SFR  = 2'd1,
        TGT_GP   = 2'd2
    } tgt_e;

    typedef struct packed {
        tgt_e          tgt;
        logic [BW-1:0] bank;
        logic [AW-1:0] loc;
    } route_t;

    typedef struct packed {
        logic [AW-1:0] mp0;
        logic [AW-1:0] mp1;
        logic [BW-1:0] bsel;
        logic [DW-1:0] acc;
    } sfr_state_t;
endpackage

// File: rtl/bdm_decode.sv
module bdm_decode
    import banked_dmem_pkg::*;
#(
    parameter logic [AW-1:0] IND0_ADDR = 8'h00,
    parameter logic [AW-1:0] IND1_ADDR = 8'h02,
    parameter logic [AW-1:0] GP_BASE   = 8'h40,
    parameter int            NUM_BANKS = 3
) (
    input  logic [AW-1:0] addr,
    input  logic [AW-1:0] mp0,
    input  logic [AW-1:0] mp1,
    input  logic [BW-1:0] bsel,
    output route_t        route
);
    logic [AW-1:0] eff;
    logic [BW-1:0] bank;
    logic          self_ref;

    always_comb begin
        eff      = addr;
        bank     = '0;
        self_ref = 1'b0;
        if (addr == IND0_ADDR) begin
            eff      = mp0;
            self_ref = (mp0 == IND0_ADDR) || (mp0 == IND1_ADDR);
        end else if (addr == IND1_ADDR) begin
            eff      = mp1;
            bank     = bsel;
            self_ref = (mp1 == IND0_ADDR) || (mp1 == IND1_ADDR);
        end

        route.loc  = eff;
        route.bank = bank;
        if (self_ref) begin
            route.tgt = TGT_NONE;
        end else if (eff >= GP_BASE) begin
            route.tgt = (int'(bank) < NUM_BANKS) ? TGT_GP : TGT_NONE;
        end else begin
            route.tgt = TGT_SFR;
        end
    end
endmodule

// File: rtl/bdm_sfr.sv
module bdm_sfr
    import banked_dmem_pkg::*;
#(
    parameter logic [AW-1:0] MP0_ADDR  = 8'h01,
    parameter logic [AW-1:0] MP1_ADDR  = 8'h03,
    parameter logic [AW-1:0] BSEL_ADDR = 8'h04,
    parameter logic [AW-1:0] ACC_ADDR  = 8'h05
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] loc,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic [AW-1:0] mp0,
    output logic [AW-1:0] mp1,
    output logic [BW-1:0] bsel
);
    sfr_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (we) begin
            if (loc == MP0_ADDR)  state_d.mp0  = wdata[AW-1:0];
            if (loc == MP1_ADDR)  state_d.mp1  = wdata[AW-1:0];
            if (loc == BSEL_ADDR) state_d.bsel = wdata[BW-1:0];
            if (loc == ACC_ADDR)  state_d.acc  = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    always_comb begin
        rdata = '0;
        if      (loc == MP0_ADDR)  rdata = DW'(state_q.mp0);
        else if (loc == MP1_ADDR)  rdata = DW'(state_q.mp1);
        else if (loc == BSEL_ADDR) rdata = DW'(state_q.bsel);
        else if (loc == ACC_ADDR)  rdata = state_q.acc;
    end

    assign mp0  = state_q.mp0;
    assign mp1  = state_q.mp1;
    assign bsel = state_q.bsel;

    AST_ACC_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (we && loc == ACC_ADDR) |=> (state_q.acc == $past(wdata))); // R8

    AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(we && loc == MP0_ADDR) |=> $stable(state_q.mp0)); // R5
endmodule

// File: rtl/bdm_gp_store.sv
module bdm_gp_store
    import banked_dmem_pkg::*;
#(
    parameter logic [AW-1:0] GP_BASE   = 8'h40,
    parameter int            NUM_BANKS = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [BW-1:0] bank,
    input  logic [AW-1:0] loc,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int GP_SIZE = (1 << AW) - int'(GP_BASE);
    localparam int DEPTH   = NUM_BANKS * GP_SIZE;
    localparam int IW      = $clog2(DEPTH);

    logic [DW-1:0] mem [DEPTH];
    int            idx_full;
    logic [IW-1:0] idx;
    logic          idx_ok;

    always_comb begin
        idx_full = int'(bank) * GP_SIZE + int'(loc) - int'(GP_BASE);
        idx_ok   = (idx_full >= 0) && (idx_full < DEPTH);
        idx      = IW'(idx_full);
    end

    always_ff @(posedge clk) begin
        if (we && idx_ok) mem[idx] <= wdata;
    end

    assign rdata = idx_ok ? mem[idx] : '0;

    AST_GP_BANK_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> (int'(bank) < NUM_BANKS)); // R6
endmodule

// File: rtl/banked_dmem.sv
module banked_dmem
    import banked_dmem_pkg::*;
#(
    parameter logic [AW-1:0] IND0_ADDR = 8'h00,
    parameter logic [AW-1:0] MP0_ADDR  = 8'h01,
    parameter logic [AW-1:0] IND1_ADDR = 8'h02,
    parameter logic [AW-1:0] MP1_ADDR  = 8'h03,
    parameter logic [AW-1:0] BSEL_ADDR = 8'h04,
    parameter logic [AW-1:0] ACC_ADDR  = 8'h05,
    parameter logic [AW-1:0] GP_BASE   = 8'h40,
    parameter int            NUM_BANKS = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic          rd_en,
    input  logic          wr_en,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    route_t        route;
    logic [AW-1:0] mp0, mp1;
    logic [BW-1:0] bsel;
    logic [DW-1:0] sfr_rdata, gp_rdata;
    logic          sfr_we, gp_we;

    bdm_decode #(
        .IND0_ADDR(IND0_ADDR), .IND1_ADDR(IND1_ADDR),
        .GP_BASE(GP_BASE), .NUM_BANKS(NUM_BANKS)
    ) u_decode (
        .addr(addr), .mp0(mp0), .mp1(mp1), .bsel(bsel), .route(route)
    );

    assign sfr_we = wr_en && (route.tgt == TGT_SFR);
    assign gp_we  = wr_en && (route.tgt == TGT_GP);

    bdm_sfr #(
        .MP0_ADDR(MP0_ADDR), .MP1_ADDR(MP1_ADDR),
        .BSEL_ADDR(BSEL_ADDR), .ACC_ADDR(ACC_ADDR)
    ) u_sfr (
        .clk(clk), .rst_n(rst_n), .we(sfr_we), .loc(route.loc),
        .wdata(wdata), .rdata(sfr_rdata),
        .mp0(mp0), .mp1(mp1), .bsel(bsel)
    );

    bdm_gp_store #(
        .GP_BASE(GP_BASE), .NUM_BANKS(NUM_BANKS)
    ) u_gp (
        .clk(clk), .rst_n(rst_n), .we(gp_we), .bank(route.bank),
        .loc(route.loc), .wdata(wdata), .rdata(gp_rdata)
    );

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            case (route.tgt)
                TGT_GP:  rdata = gp_rdata;
                TGT_SFR: rdata = sfr_rdata;
                default: rdata = '0;
            endcase
        end
    end

    AST_DIRECT_BANK0: assert property (@(posedge clk) disable iff (!rst_n)
        (addr != IND1_ADDR && route.tgt == TGT_GP) |-> (route.bank == '0)); // R2

    AST_SELF_REF_NULL: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == IND0_ADDR && (mp0 == IND0_ADDR || mp0 == IND1_ADDR))
            |-> (route.tgt == TGT_NONE)); // R5

    AST_IND1_SELF_NULL: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == IND1_ADDR && (mp1 == IND0_ADDR || mp1 == IND1_ADDR))
            |=> ($stable(mp0) && $stable(mp1))); // R5
endmodule

// File: tb/banked_dmem_tb.sv
module banked_dmem_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] addr = '0;
    logic       rd_en = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;

    typedef struct {
        logic [7:0] exp;
        logic [7:0] a;
        string      req;
    } item_t;

    item_t exp_q[$];
    event  chk_ev;
    int    errors = 0;
    int    checks = 0;
    bit    done = 1'b0;

    always #2.5 clk = ~clk;

    banked_dmem u_dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .rd_en(rd_en),
        .wr_en(wr_en), .wdata(wdata), .rdata(rdata)
    );

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1; rd_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [7:0] e, input string req);
        item_t it;
        @(negedge clk);
        addr = a; wr_en = 1'b0; rd_en = 1'b1;
        it.exp = e; it.a = a; it.req = req;
        exp_q.push_back(it);
        -> chk_ev;
    endtask

    task automatic rd_idle(input logic [7:0] a, input string req);
        item_t it;
        @(negedge clk);
        addr = a; wr_en = 1'b0; rd_en = 1'b0;
        it.exp = 8'h00; it.a = a; it.req = req;
        exp_q.push_back(it);
        -> chk_ev;
    endtask

    initial begin : monitor
        item_t it;
        forever begin
            @(chk_ev);
            #1;
            while (exp_q.size() > 0) begin
                it = exp_q.pop_front();
                checks++;
                if (rdata !== it.exp) begin
                    errors++;
                    $display("FAIL %s addr=%02h actual=%02h expected=%02h",
                             it.req, it.a, rdata, it.exp);
                end
            end
        end
    end

    initial begin : stimulus
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd(8'h01, 8'h00, "R1");
        rd(8'h03, 8'h00, "R1");
        rd(8'h04, 8'h00, "R1");
        rd(8'h05, 8'h00, "R1");
        // R2 direct bank 0
        wr(8'h40, 8'h11);
        wr(8'hFF, 8'h22);
        rd(8'h40, 8'h11, "R2");
        rd(8'hFF, 8'h22, "R2");
        // R3 first pointer
        wr(8'h01, 8'h80);
        wr(8'h00, 8'h5A);
        rd(8'h80, 8'h5A, "R3");
        rd(8'h00, 8'h5A, "R3");
        wr(8'h01, 8'h40);
        rd(8'h00, 8'h11, "R3");
        // R4 second pointer with banks
        wr(8'h04, 8'h01);
        wr(8'h03, 8'h40);
        wr(8'h02, 8'hA1);
        wr(8'h04, 8'h02);
        wr(8'h02, 8'hB2);
        rd(8'h40, 8'h11, "R4");
        rd(8'h02, 8'hB2, "R4");
        wr(8'h04, 8'h01);
        rd(8'h02, 8'hA1, "R4");
        wr(8'h04, 8'h00);
        rd(8'h02, 8'h11, "R4");
        // R9 bank select width
        wr(8'h04, 8'hFE);
        rd(8'h04, 8'h02, "R9");
        // R6 bank select 3
        wr(8'h04, 8'h03);
        rd(8'h02, 8'h00, "R6");
        wr(8'h02, 8'h77);
        wr(8'h04, 8'h00);
        rd(8'h40, 8'h11, "R6");
        wr(8'h04, 8'h01);
        rd(8'h02, 8'hA1, "R6");
        wr(8'h04, 8'h02);
        rd(8'h02, 8'hB2, "R6");
        // R5 self reference
        wr(8'h05, 8'h3C);
        wr(8'h01, 8'h00);
        rd(8'h00, 8'h00, "R5");
        wr(8'h00, 8'h99);
        rd(8'h01, 8'h00, "R5");
        rd(8'h03, 8'h40, "R5");
        rd(8'h05, 8'h3C, "R5");
        wr(8'h03, 8'h02);
        rd(8'h02, 8'h00, "R5");
        wr(8'h02, 8'h66);
        rd(8'h03, 8'h02, "R5");
        rd(8'h01, 8'h00, "R5");
        rd(8'h05, 8'h3C, "R5");
        // R8 accumulator
        rd(8'h05, 8'h3C, "R8");
        wr(8'h01, 8'h05);
        rd(8'h00, 8'h3C, "R8");
        wr(8'h00, 8'hC3);
        rd(8'h05, 8'hC3, "R8");
        // R7 unused special locations
        wr(8'h10, 8'hAB);
        rd(8'h10, 8'h00, "R7");
        wr(8'h3F, 8'hCD);
        rd(8'h3F, 8'h00, "R7");
        // R10 read strobe low
        rd_idle(8'h05, "R10");
        rd_idle(8'h40, "R10");
        @(negedge clk);
        rd_en = 1'b0;
        repeat (2) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : watchdog
        #(5 * 100000);
        if (!done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule